// File: doc/BRIEF.md
# Serial Bus Operating-Mode Controller

This block keeps the operating mode of a serial bus port that can run either as an I2C-style two-wire bus or as a clocked synchronous serial link. A register write port lets software choose master or slave operation, transmit or receive direction, and a 4-bit transfer-clock select value. Hardware events from the bit-level logic can also change the mode: losing arbitration, a receive overrun, and a match on the slave address.

The block watches the bits that follow a start condition. It shifts them in MSB first and compares the first seven with a programmed slave address. The eighth bit gives the read/write direction. The block drives the current mode, the clock-select value, a clock-output enable for the synchronous format, and a one-cycle address-match pulse. The shifter, pad drivers and baud generator sit outside the block and appear only as event inputs.

Top module: `sbus_mode_ctl`

## Requirements
- R1: After a synchronous active-low reset, `mode_o` is 2'b00 (slave receive), `cks_o` is 4'b0000, `clk_oe` is 0, `addr_match` is 0 and `rd_data` reads 8'h00.
- R2: `rd_data` shows the master bit in bit 5, the transmit bit in bit 4 and the clock select in bits 3..0, with bits 7..6 reading 0. A write sets `cks_o` to `wr_data[3:0]` at the next clock edge.
- R3: `mode_o` is {master bit, transmit bit}: 00 slave receive, 01 slave transmit, 10 master receive, 11 master transmit. A write takes the master bit from `wr_data[5]` at the next edge.
- R4: While `frame_busy` is 1, a write to the transmit bit (`wr_data[4]`) is held and `mode_o[0]` keeps its value. The held value is applied at the first clock edge where `frame_busy` is 0.
- R5: With `fmt_sync`=0 and the master bit set, an `arb_lost` pulse sets `mode_o` to 00 at the next edge. With `fmt_sync`=1, `arb_lost` has no effect.
- R6: With `fmt_sync`=1 and the block in master receive (10), an `overrun` pulse sets `mode_o` to 00. With `fmt_sync`=0, or in any other mode, `overrun` has no effect.
- R7: After `start_det`, the block samples `bit_data` on each `bit_valid`. If the first seven bits equal `slave_addr` (MSB first) and the mode is slave receive when the eighth bit is sampled, `addr_match` is high for exactly the one cycle after that edge. If the eighth bit is also 1, `mode_o` becomes 01 at that same edge. A wrong address, or any other mode, gives no pulse and leaves the mode unchanged.
- R8: `clk_oe` is 1 exactly when `fmt_sync` is 1 and the master bit is 1.
- R9: When a hardware mode event (arbitration loss, then overrun, then address match, in that priority order) coincides with a write, the event sets the mode bits and the write's mode bits are discarded. The write's clock-select field still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 6 | Write data: [5] master, [4] transmit, [3:0] clock select |
| rd_data | output | 8 | Register read-back with current values |
| fmt_sync | input | 1 | 1 = clocked synchronous format, 0 = I2C format |
| frame_busy | input | 1 | A transfer frame is in progress |
| arb_lost | input | 1 | Arbitration-loss event pulse |
| overrun | input | 1 | Receive overrun event pulse |
| start_det | input | 1 | Start condition detected pulse |
| bit_valid | input | 1 | A received bit is present on bit_data |
| bit_data | input | 1 | Received bit value |
| slave_addr | input | 7 | Programmed own slave address |
| mode_o | output | 2 | Current {master, transmit} mode |
| cks_o | output | 4 | Transfer-clock select |
| clk_oe | output | 1 | Clock output enable |
| addr_match | output | 1 | One-cycle slave address match pulse |

## Verification
On every cycle the embedded assertions check the following: the drop to slave receive after an effective arbitration loss or overrun, the transmit bit being held while a frame is busy, the pickup of the clock-select field, the single-cycle width of the match pulse, and the move to slave transmit on a read match. The directed scenarios are needed for the rest. They cover the deferred transmit-bit write landing once the frame ends, the events being ignored in the wrong format or mode, mismatching and write-direction addresses, and hardware events winning over a write in the same cycle.

// File: rtl/sbus_mode_pkg.sv
// Package: shared mode encoding and register field positions for the
// serial bus mode controller. Assumes a 2-bit mode and a 4-bit clock select.
package sbus_mode_pkg;

    localparam int CKS_W   = 4;
    localparam int ADDR_W  = 7;
    localparam int WR_W    = 6;
    localparam int RD_W    = 8;
    localparam int MST_POS = 5;
    localparam int TRS_POS = 4;

    typedef enum logic [1:0] {
        MODE_SLV_RX = 2'b00,
        MODE_SLV_TX = 2'b01,
        MODE_MST_RX = 2'b10,
        MODE_MST_TX = 2'b11
    } sbus_mode_e;

endpackage

// File: rtl/sbus_addr_cmp.sv
// Module: collects the bits after a start condition (MSB first) and flags
// the frame in which the bit after the address is sampled.
// Assumes start_det wins over bit_valid in the same cycle. Bits beyond the
// address byte are ignored until the next start.
module sbus_addr_cmp #(
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_det,
    input  logic          bit_valid,
    input  logic          bit_data,
    input  logic [AW-1:0] own_addr,
    output logic          hit,
    output logic          hit_rd
);
    localparam int CNT_W = $clog2(AW + 1);

    logic [AW-1:0]    shreg;
    logic [CNT_W-1:0] cnt;
    logic             armed;
    logic             last_bit;

    // Purpose: the direction bit arrives after AW address bits.
    assign last_bit = armed && bit_valid && !start_det && (cnt == CNT_W'(AW));
    assign hit      = last_bit && (shreg == own_addr);
    assign hit_rd   = hit && bit_data;

    // Purpose: shift address bits and count them after each start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            cnt   <= '0;
            armed <= 1'b0;
        end else if (start_det) begin
            shreg <= '0;
            cnt   <= '0;
            armed <= 1'b1;
        end else if (armed && bit_valid) begin
            if (last_bit) begin
                armed <= 1'b0;
            end else begin
                shreg <= {shreg[AW-2:0], bit_data};
                cnt   <= cnt + 1'b1;
            end
        end
    end

    a_r7_hit_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !hit);

endmodule

// File: rtl/sbus_mode_state.sv
// Module: holds the master and transmit bits and the clock select.
// Applies hardware overrides with priority arbitration loss > overrun >
// address match > software write. A transmit-bit write made during a
// frame is parked and applied once the frame ends.
module sbus_mode_state #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fmt_sync,
    input  logic          wr_en,
    input  logic          wr_mst,
    input  logic          wr_trs,
    input  logic [CW-1:0] wr_cks,
    input  logic          frame_busy,
    input  logic          arb_lost,
    input  logic          overrun,
    input  logic          match_rd,
    output logic          mst_o,
    output logic          trs_o,
    output logic [CW-1:0] cks_o
);
    logic mst_q, trs_q, pend_q, pend_val_q;
    logic arb_ev, ovr_ev, am_ev, hw_ev;

    // Purpose: qualify each hardware event by format and current mode.
    assign arb_ev = arb_lost && !fmt_sync && mst_q;
    assign ovr_ev = overrun && fmt_sync && mst_q && !trs_q;
    assign am_ev  = match_rd && !mst_q && !trs_q;
    assign hw_ev  = arb_ev || ovr_ev || am_ev;

    // Purpose: update the mode bits and the parked transmit-bit write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mst_q      <= 1'b0;
            trs_q      <= 1'b0;
            pend_q     <= 1'b0;
            pend_val_q <= 1'b0;
        end else if (arb_ev) begin
            mst_q  <= 1'b0;
            trs_q  <= 1'b0;
            pend_q <= 1'b0;
        end else if (ovr_ev) begin
            mst_q  <= 1'b0;
            pend_q <= 1'b0;
        end else if (am_ev) begin
            trs_q  <= 1'b1;
            pend_q <= 1'b0;
        end else if (wr_en) begin
            mst_q <= wr_mst;
            if (frame_busy) begin
                pend_q     <= 1'b1;
                pend_val_q <= wr_trs;
            end else begin
                trs_q  <= wr_trs;
                pend_q <= 1'b0;
            end
        end else if (pend_q && !frame_busy) begin
            trs_q  <= pend_val_q;
            pend_q <= 1'b0;
        end
    end

    // Purpose: clock select follows every write; no hardware source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cks_o <= '0;
        end else if (wr_en) begin
            cks_o <= wr_cks;
        end
    end

    assign mst_o = mst_q;
    assign trs_o = trs_q;

    a_r5_arb_to_slave_rx: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_lost && !fmt_sync && mst_o) |=> (!mst_o && !trs_o));

    a_r6_ovr_to_slave_rx: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && fmt_sync && mst_o && !trs_o) |=> (!mst_o && !trs_o));

    a_r4_trs_held_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_busy && !hw_ev) |=> $stable(trs_o));

    a_r2_cks_written: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cks_o == $past(wr_cks)));

endmodule

// File: rtl/sbus_mode_ctl.sv
// Module: top of the serial bus operating-mode controller. Joins the
// address comparator and mode state, and forms read-back, clock enable
// and the address-match pulse. Assumes event inputs are already
// synchronous to clk.
module sbus_mode_ctl
    import sbus_mode_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WR_W-1:0]   wr_data,
    output logic [RD_W-1:0]   rd_data,
    input  logic              fmt_sync,
    input  logic              frame_busy,
    input  logic              arb_lost,
    input  logic              overrun,
    input  logic              start_det,
    input  logic              bit_valid,
    input  logic              bit_data,
    input  logic [ADDR_W-1:0] slave_addr,
    output logic [1:0]        mode_o,
    output logic [CKS_W-1:0]  cks_o,
    output logic              clk_oe,
    output logic              addr_match
);
    logic hit, hit_rd, mst, trs, in_srx, match_q;

    sbus_addr_cmp #(.AW(ADDR_W)) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_det (start_det),
        .bit_valid (bit_valid),
        .bit_data  (bit_data),
        .own_addr  (slave_addr),
        .hit       (hit),
        .hit_rd    (hit_rd)
    );

    sbus_mode_state #(.CW(CKS_W)) u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .fmt_sync   (fmt_sync),
        .wr_en      (wr_en),
        .wr_mst     (wr_data[MST_POS]),
        .wr_trs     (wr_data[TRS_POS]),
        .wr_cks     (wr_data[CKS_W-1:0]),
        .frame_busy (frame_busy),
        .arb_lost   (arb_lost),
        .overrun    (overrun),
        .match_rd   (hit_rd),
        .mst_o      (mst),
        .trs_o      (trs),
        .cks_o      (cks_o)
    );

    // Purpose: address match only counts in slave receive.
    assign in_srx = (sbus_mode_e'({mst, trs}) == MODE_SLV_RX);

    // Purpose: register the one-cycle match pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) match_q <= 1'b0;
        else        match_q <= hit && in_srx;
    end

    assign addr_match = match_q;
    assign mode_o     = {mst, trs};
    assign clk_oe     = fmt_sync && mst;
    assign rd_data    = {{(RD_W - 2 - CKS_W){1'b0}}, mst, trs, cks_o};

    a_r7_read_match_to_stx: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_rd && in_srx) |=> (mode_o == MODE_SLV_TX && addr_match));

    a_r7_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        addr_match |=> !addr_match);

endmodule

// File: tb/sbus_mode_ctl_tb.sv
module sbus_mode_ctl_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [5:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       fmt_sync = 1'b0, frame_busy = 1'b0, arb_lost = 1'b0, overrun = 1'b0;
    logic       start_det = 1'b0, bit_valid = 1'b0, bit_data = 1'b0;
    logic [6:0] slave_addr = 7'h5A;
    logic [1:0] mode_o;
    logic [3:0] cks_o;
    logic       clk_oe, addr_match;

    int n_chk = 0;
    int n_bad = 0;

    sbus_mode_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .fmt_sync(fmt_sync), .frame_busy(frame_busy),
        .arb_lost(arb_lost), .overrun(overrun), .start_det(start_det),
        .bit_valid(bit_valid), .bit_data(bit_data), .slave_addr(slave_addr),
        .mode_o(mode_o), .cks_o(cks_o), .clk_oe(clk_oe), .addr_match(addr_match)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [5:0] d);
        wr_en = 1'b1; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic send_byte(logic [7:0] b);
        start_det = 1'b1; step(); start_det = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            bit_valid = 1'b1; bit_data = b[i];
            step();
            bit_valid = 1'b0;
            if (i > 0) chk("R7 no early pulse", addr_match, 0);
        end
    endtask

    task automatic t_reset();
        chk("R1 mode", mode_o, 0);
        chk("R1 cks", cks_o, 0);
        chk("R1 clk_oe", clk_oe, 0);
        chk("R1 match", addr_match, 0);
        chk("R1 rd", rd_data, 8'h00);
    endtask

    task automatic t_write();
        fmt_sync = 1'b0;
        wr(6'h2A);
        chk("R2 rd", rd_data, 8'h2A);
        chk("R3 mode MRX", mode_o, 2'b10);
        wr(6'h3F);
        chk("R3 mode MTX", mode_o, 2'b11);
        chk("R2 cks", cks_o, 4'hF);
        wr(6'h15);
        chk("R3 mode STX", mode_o, 2'b01);
        chk("R2 rd", rd_data, 8'h15);
        wr(6'h00);
    endtask

    task automatic t_trs_defer();
        frame_busy = 1'b1;
        wr(6'h10);
        chk("R4 held", mode_o, 2'b00);
        step();
        chk("R4 still held", mode_o, 2'b00);
        frame_busy = 1'b0;
        step();
        chk("R4 applied", mode_o, 2'b01);
        wr(6'h00);
    endtask

    task automatic t_arb();
        fmt_sync = 1'b0;
        wr(6'h30);
        arb_lost = 1'b1; step(); arb_lost = 1'b0;
        chk("R5 arb i2c", mode_o, 2'b00);
        fmt_sync = 1'b1;
        wr(6'h30);
        arb_lost = 1'b1; step(); arb_lost = 1'b0;
        chk("R5 arb ignored sync", mode_o, 2'b11);
        wr(6'h00);
    endtask

    task automatic t_ovr();
        fmt_sync = 1'b1;
        wr(6'h20);
        overrun = 1'b1; step(); overrun = 1'b0;
        chk("R6 ovr sync MRX", mode_o, 2'b00);
        wr(6'h30);
        overrun = 1'b1; step(); overrun = 1'b0;
        chk("R6 ovr ignored MTX", mode_o, 2'b11);
        fmt_sync = 1'b0;
        wr(6'h20);
        overrun = 1'b1; step(); overrun = 1'b0;
        chk("R6 ovr ignored i2c", mode_o, 2'b10);
        wr(6'h00);
    endtask

    task automatic t_clkoe();
        fmt_sync = 1'b1;
        wr(6'h20);
        chk("R8 oe on", clk_oe, 1);
        fmt_sync = 1'b0; step();
        chk("R8 oe off i2c", clk_oe, 0);
        fmt_sync = 1'b1;
        wr(6'h10);
        chk("R8 oe off slave", clk_oe, 0);
        fmt_sync = 1'b0;
        wr(6'h00);
    endtask

    task automatic t_addr();
        send_byte({7'h5A, 1'b1});
        chk("R7 pulse rd", addr_match, 1);
        chk("R7 to STX", mode_o, 2'b01);
        step();
        chk("R7 one cycle", addr_match, 0);
        wr(6'h00);
        send_byte({7'h5A, 1'b0});
        chk("R7 pulse wr", addr_match, 1);
        chk("R7 wr stays SRX", mode_o, 2'b00);
        send_byte({7'h5B, 1'b1});
        chk("R7 wrong addr", addr_match, 0);
        chk("R7 wrong addr mode", mode_o, 2'b00);
        wr(6'h20);
        send_byte({7'h5A, 1'b1});
        chk("R7 not slave", addr_match, 0);
        chk("R7 not slave mode", mode_o, 2'b10);
        wr(6'h00);
    endtask

    task automatic t_prio();
        fmt_sync = 1'b0;
        wr(6'h30);
        wr_en = 1'b1; wr_data = 6'h3B; arb_lost = 1'b1;
        step();
        wr_en = 1'b0; arb_lost = 1'b0;
        chk("R9 arb over write", mode_o, 2'b00);
        chk("R9 cks kept", cks_o, 4'hB);
        start_det = 1'b1; step(); start_det = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            bit_valid = 1'b1; bit_data = (i == 0) ? 1'b1 : slave_addr[i-1];
            if (i == 0) begin wr_en = 1'b1; wr_data = 6'h22; end
            step();
            bit_valid = 1'b0; wr_en = 1'b0;
        end
        chk("R9 match over write", mode_o, 2'b01);
        chk("R9 cks match", cks_o, 4'h2);
        wr(6'h00);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog act=1 exp=0");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_write();
        t_trs_defer();
        t_arb();
        t_ovr();
        t_clkoe();
        t_addr();
        t_prio();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule